// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a small register-programmed SPI master that talks to one serial flash device. Software places a command byte and a 24-bit flash address in a command register, up to four payload bytes in a data register, and writes a control register that holds a transmit byte count and a receive byte count with a start bit set. The engine then lowers chip select and shifts the frame out in SPI mode 0.

The transmit count covers the command byte, the address bytes and the payload bytes together. When the count is four or more, the three address bytes follow the command byte and the payload follows them. A smaller count sends payload straight after the command byte, which suits short status-register writes. Receive bytes are clocked in only after the last transmit bit. They are packed little-endian into the data register when the frame ends, and a busy flag in the control register stays high for the whole frame.

Top module: `sfl_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, the command and data registers read 0 and the control register reads 0x00000001 (transmit count 1, receive count 0, busy 0).
- R2: Register select 0 is control: bits 3:0 are the transmit count, bits 6:4 the receive count, bit 7 is start (write only, reads 0) and bit 8 is busy (read only). Select 1 is the command register (command byte in bits 7:0, flash address in bits 31:8). Select 2 is the data register. Select 3 reads 0. Written values read back.
- R3: A control write with bit 7 set while idle makes busy read 1 and drives chip select low from the next cycle. Busy returns to 0 in the same cycle that chip select is released.
- R4: Transmit byte k (k = 0 first) is the command byte for k = 0. With a transmit count of 4 or more, bytes 1..3 are address bits 23:16, 15:8 and 7:0, and byte 4+j is data bits 8j+7:8j. With a count of 2 or 3, byte 1+j is data bits 8j+7:8j. Every byte goes out MSB first.
- R5: Receive byte j, taken after all transmit bytes, is written to data bits 8j+7:8j when the frame ends, and lanes that were not received become 0. A frame with receive count 0 leaves the data register unchanged.
- R6: MOSI is 0 for every bit of the receive phase. The frame has exactly 8 x (transmit + receive) SCK pulses.
- R7: SCK idles low and MOSI changes only while SCK is low. MISO is sampled on SCK rising edges. The first rising edge comes SCK_DIV/2 clock cycles after chip select falls, and the SCK period is SCK_DIV clock cycles.
- R8: A transmit count of 0 is stored as 1, and one above 8 is stored as 8. A receive count above 4 is stored as 4. The stored values read back and set the frame length.
- R9: While busy, register writes (a start request included) are ignored, and reads of the data register return the contents from before the frame.
- R10: A transmit count of 1 with a receive count of 0 sends the command byte alone, in exactly 8 SCK pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach from the ports is a register access that lands in the middle of a frame. It needs a started frame that is long enough, with writes to the command, data and control registers (including a second start) and a data read timed inside the busy window. The busy-window scenario starts a 24-bit frame, reads the data register a few cycles in, then issues the conflicting writes. After the frame it checks that the command and count fields are unchanged, that the data holds only the received lanes, and that chip select fell exactly once. A bench flash model answers every SCK edge from a seeded byte stream, so each receive lane can be predicted from the transmit count alone.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  localparam int TX_MAX = 8;
  localparam int RX_MAX = 4;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_CMD  = 2'd1,
    RG_DATA = 2'd2,
    RG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } eng_state_e;

  // Transmit count: at least the command byte, at most command+address+4 data.
  function automatic logic [3:0] fit_tx(input logic [3:0] raw);
    if (raw == 4'd0) return 4'd1;
    if (raw > 4'(TX_MAX)) return 4'(TX_MAX);
    return raw;
  endfunction

  function automatic logic [2:0] fit_rx(input logic [2:0] raw);
    return (raw > 3'(RX_MAX)) ? 3'(RX_MAX) : raw;
  endfunction

  // Number of SCK pulses in a frame.
  function automatic logic [6:0] frame_bits(input logic [3:0] tx, input logic [2:0] rx);
    return {(tx + {1'b0, rx}), 3'b000};
  endfunction

  // Byte k of the transmit phase.
  function automatic logic [7:0] pick_tx_byte(input logic [31:0] cmd, input logic [31:0] data,
                                              input logic [3:0] tx, input logic [3:0] idx);
    logic [3:0] lane;
    if (idx == 4'd0) return cmd[7:0];
    if (tx >= 4'd4) begin
      case (idx)
        4'd1: return cmd[31:24];
        4'd2: return cmd[23:16];
        4'd3: return cmd[15:8];
        default: lane = idx - 4'd4;
      endcase
    end else begin
      lane = idx - 4'd1;
    end
    return data[{lane[1:0], 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/sfl_sck_timer.sv
module sfl_sck_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF) + 1;

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!en || tick)   cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sfl_regs.sv
module sfl_regs
  import sfl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        busy,
  input  logic        done,
  input  logic [31:0] rx_word,
  output logic [31:0] cmd_q,
  output logic [31:0] data_q,
  output logic [3:0]  tx_cnt_q,
  output logic [2:0]  rx_cnt_q,
  output logic        start
);
  logic wr_ok;

  assign wr_ok = reg_we && !busy;
  assign start = wr_ok && (reg_addr == RG_CTRL) && reg_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      data_q   <= '0;
      tx_cnt_q <= 4'd1;
      rx_cnt_q <= 3'd0;
    end else if (wr_ok) begin
      case (reg_addr)
        RG_CTRL: begin
          tx_cnt_q <= fit_tx(reg_wdata[3:0]);
          rx_cnt_q <= fit_rx(reg_wdata[6:4]);
        end
        RG_CMD:  cmd_q  <= reg_wdata;
        RG_DATA: data_q <= reg_wdata;
        default: ;
      endcase
    end else if (done && (rx_cnt_q != 3'd0)) begin
      data_q <= rx_word;
    end
  end

  always_comb begin
    case (reg_addr)
      RG_CTRL: reg_rdata = {23'd0, busy, 1'b0, rx_cnt_q, tx_cnt_q};
      RG_CMD:  reg_rdata = cmd_q;
      RG_DATA: reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == RG_CMD) |=> $stable(cmd_q)); // R9
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q)); // R9

endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter
  import sfl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tick,
  input  logic [31:0] cmd,
  input  logic [31:0] data,
  input  logic [3:0]  tx_cnt,
  input  logic [2:0]  rx_cnt,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [31:0] rx_word,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi
);
  eng_state_e state_q;
  logic [6:0] bit_idx_q;
  logic [3:0] byte_idx;
  logic [2:0] bit_in;
  logic       in_tx;
  logic       last_bit;
  logic [7:0] cur_byte;
  logic [3:0] rx_lane;

  assign byte_idx = bit_idx_q[6:3];
  assign bit_in   = bit_idx_q[2:0];
  assign in_tx    = byte_idx < tx_cnt;
  assign last_bit = (bit_idx_q == frame_bits(tx_cnt, rx_cnt) - 7'd1);
  assign cur_byte = pick_tx_byte(cmd, data, tx_cnt, byte_idx);
  assign rx_lane  = byte_idx - tx_cnt;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_HOLD) && tick;
  assign mosi     = (state_q == ST_SHIFT) && in_tx && cur_byte[~bit_in];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_idx_q <= '0;
      rx_word   <= '0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q   <= ST_SHIFT;
          cs_n      <= 1'b0;
          bit_idx_q <= '0;
          rx_word   <= '0;
        end
        ST_SHIFT: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            if (!in_tx) rx_word[{rx_lane[1:0], ~bit_in}] <= miso;
          end else begin
            sck <= 1'b0;
            if (last_bit) state_q <= ST_HOLD;
            else          bit_idx_q <= bit_idx_q + 7'd1;
          end
        end
        ST_HOLD: if (tick) begin
          cs_n    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R3
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !busy); // R3
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R7
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && busy)); // R9

endmodule

// File: rtl/sfl_cmd_engine.sv
module sfl_cmd_engine #(
  parameter int SCK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;

  logic [31:0] cmd_q, data_q, rx_word;
  logic [3:0]  tx_cnt;
  logic [2:0]  rx_cnt;
  logic        start, busy, done, tick;

  sfl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .rx_word(rx_word), .cmd_q(cmd_q), .data_q(data_q), .tx_cnt_q(tx_cnt),
    .rx_cnt_q(rx_cnt), .start(start)
  );

  sfl_sck_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  sfl_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .cmd(cmd_q),
    .data(data_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .miso(spi_miso),
    .busy(busy), .done(done), .rx_word(rx_word), .sck(spi_sck),
    .cs_n(spi_cs_n), .mosi(spi_mosi)
  );

endmodule

// File: tb/sfl_cmd_engine_tb_top.sv
module sfl_cmd_engine_tb_top;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [127:0] cap = '0;
  int           bit_cnt = 0;
  int           frames = 0;
  logic [7:0]   seed = 8'h00;

  always #2 clk = ~clk;

  sfl_cmd_engine #(.SCK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp_at(input logic [7:0] s, input int k);
    return s ^ 8'((k * 37) + 11);
  endfunction

  function automatic logic miso_bit(input logic [7:0] s, input int b);
    logic [7:0] v;
    if (b >= 96) return 1'b0;
    v = resp_at(s, b / 8);
    return v[7 - (b % 8)];
  endfunction

  assign spi_miso = miso_bit(seed, bit_cnt);

  // Flash model: capture MOSI on each SCK rise inside a frame.
  always begin
    @(negedge spi_cs_n);
    frames = frames + 1;
    bit_cnt = 0;
    cap = '0;
    while (!spi_cs_n) begin
      @(posedge spi_sck or posedge spi_cs_n);
      if (spi_sck && !spi_cs_n) begin
        cap = {cap[126:0], spi_mosi};
        bit_cnt = bit_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    rd(2'd0, v);
    while (v[8]) begin
      @(negedge clk);
      rd(2'd0, v);
    end
  endtask

  function automatic int clamp_tx(input int t);
    return (t == 0) ? 1 : ((t > 8) ? 8 : t);
  endfunction

  function automatic int clamp_rx(input int r);
    return (r > 4) ? 4 : r;
  endfunction

  function automatic logic [7:0] exp_tx_byte(input logic [7:0] op, input logic [23:0] adr,
                                             input logic [31:0] dat, input int txe, input int i);
    if (i == 0) return op;
    if (txe >= 4) begin
      if (i <= 3) return adr[8*(3-i) +: 8];
      return dat[8*(i-4) +: 8];
    end
    return dat[8*(i-1) +: 8];
  endfunction

  // Launch one frame, wait for it, check MOSI stream and resulting data word.
  task automatic run_frame(input string name, input logic [7:0] op, input logic [23:0] adr,
                           input logic [31:0] dat, input int txraw, input int rxraw,
                           input logic [7:0] sd);
    int txe, rxe, n;
    logic [127:0] exp, mask;
    logic [31:0] got, edat;
    txe = clamp_tx(txraw);
    rxe = clamp_rx(rxraw);
    n = 8 * (txe + rxe);
    seed = sd;
    wr(2'd1, {adr, op});
    wr(2'd2, dat);
    wr(2'd0, {24'd0, 1'b1, 3'(rxraw), 4'(txraw)});
    wait_idle();
    exp = '0;
    for (int i = 0; i < txe; i++) exp = {exp[119:0], exp_tx_byte(op, adr, dat, txe, i)};
    exp = exp << (8 * rxe);
    mask = (128'd1 << n) - 128'd1;
    chk("R6", {name, " pulse count"}, 128'(bit_cnt), 128'(n));
    chk("R4", {name, " mosi stream"}, cap & mask, exp);
    edat = dat;
    if (rxe > 0) begin
      edat = '0;
      for (int j = 0; j < rxe; j++) edat[8*j +: 8] = resp_at(sd, txe + j);
    end
    rd(2'd2, got);
    chk("R5", {name, " data word"}, 128'(got), 128'(edat));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1", "ctrl reset", 128'(v), 128'h1);
    rd(2'd1, v); chk("R1", "cmd reset", 128'(v), 128'h0);
    rd(2'd2, v); chk("R1", "data reset", 128'(v), 128'h0);
    chk("R1", "cs_n/sck reset", 128'({spi_cs_n, spi_sck}), 128'b10);
    wr(2'd1, 32'hCAFE_F00D);
    rd(2'd1, v); chk("R2", "cmd readback", 128'(v), 128'hCAFE_F00D);
    rd(2'd3, v); chk("R2", "unused select", 128'(v), 128'h0);
    wr(2'd0, 32'h0000_0023);
    rd(2'd0, v); chk("R2", "ctrl fields", 128'(v), 128'h23);
  endtask

  task automatic t_opcode_only();
    logic [31:0] v;
    int n;
    wr(2'd2, 32'h1122_3344);
    wr(2'd1, 32'h0000_0006);
    seed = 8'h5C;
    wr(2'd0, 32'h0000_0081);
    rd(2'd0, v);
    chk("R3", "busy after start", 128'(v[8]), 128'h1);
    chk("R3", "cs low after start", 128'(spi_cs_n), 128'h0);
    n = 0;
    while (!spi_sck) begin @(negedge clk); n++; end
    chk("R7", "cs to first rise", 128'(n), 128'(HALF));
    n = 0;
    while (spi_sck) begin @(negedge clk); n++; end
    while (!spi_sck) begin @(negedge clk); n++; end
    chk("R7", "sck period", 128'(n), 128'(DIV));
    wait_idle();
    chk("R3", "cs released at idle", 128'(spi_cs_n), 128'h1);
    chk("R10", "opcode only pulses", 128'(bit_cnt), 128'd8);
    chk("R10", "opcode only byte", 128'(cap[7:0]), 128'h06);
    rd(2'd2, v); chk("R5", "rx0 keeps data", 128'(v), 128'h1122_3344);
  endtask

  task automatic t_program();
    run_frame("program8", 8'h02, 24'h123456, 32'hDDCC_BBAA, 8, 0, 8'h00);
    run_frame("addr_only", 8'hD8, 24'h0A0B0C, 32'h0, 4, 0, 8'h00);
  endtask

  task automatic t_short();
    run_frame("tx2", 8'h01, 24'hFFFFFF, 32'h0000_00F5, 2, 0, 8'h00);
    run_frame("tx3", 8'h01, 24'hFFFFFF, 32'h0000_A7F5, 3, 0, 8'h00);
  endtask

  task automatic t_read();
    run_frame("read4", 8'h03, 24'hABCDEF, 32'h0, 4, 4, 8'h3C);
    run_frame("id3", 8'h9F, 24'h0, 32'hFFFF_FFFF, 1, 3, 8'hA1);
    run_frame("tx5rx2", 8'h0B, 24'h000100, 32'h0000_0077, 5, 2, 8'h66);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    run_frame("tx0", 8'h04, 24'h0, 32'h5555_5555, 0, 0, 8'h00);
    rd(2'd0, v); chk("R8", "tx0 stored as 1", 128'(v[6:0]), 128'h01);
    run_frame("tx15rx7", 8'h02, 24'h010203, 32'h0807_0605, 15, 7, 8'h99);
    rd(2'd0, v); chk("R8", "clamped counts", 128'(v[6:0]), 128'h48);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v, edat;
    int f0;
    wr(2'd2, 32'h5A5A_5A5A);
    wr(2'd1, 32'h0000_0005);
    seed = 8'h47;
    f0 = frames;
    wr(2'd0, 32'h0000_00A1);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R9", "data read during busy", 128'(v), 128'h5A5A_5A5A);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0000_0088);
    wait_idle();
    repeat (30) @(negedge clk);
    rd(2'd1, v); chk("R9", "cmd kept", 128'(v), 128'h05);
    rd(2'd0, v); chk("R9", "ctrl kept", 128'(v), 128'h21);
    edat = {16'h0, resp_at(8'h47, 2), resp_at(8'h47, 1)};
    rd(2'd2, v); chk("R9", "data after busy", 128'(v), 128'(edat));
    chk("R9", "single frame", 128'(frames - f0), 128'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_opcode_only();
    t_program();
    t_short();
    t_read();
    t_clamp();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule